// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block inspects the destination address at the head of each received Ethernet frame and returns one verdict per frame: keep or drop. The address comes in as six bytes on a byte stream with a byte-valid qualifier and a start-of-frame strobe. While the bytes arrive, a CRC-32 over them is accumulated one byte per valid cycle. When the sixth byte arrives, the finished CRC indexes a 64-bit multicast hash table, the full address is compared with a bank of exact-match unicast entries, and the mode bits are applied. The verdict is then registered.

Configuration is loaded through a plain write port. The port holds three mode bits (accept-everything, accept-any-group-address and hash-filtered group addresses), the two 32-bit halves of the hash table, and the exact-match entries. Each entry is written as a low word and a high word, and the high word carries the entry's enable bit. Entry 0 is meant for the station's own address.

Control is a three-state machine. `ST_IDLE` waits for the first frame. `ST_ADDR` collects address bytes. `ST_HOLD` ignores the rest of a frame until the next start. The transitions are: START (start strobe with a valid byte, from any state, to `ST_ADDR`), COMPLETE (sixth byte taken, `ST_ADDR` to `ST_HOLD`) and STAY (anything else keeps the state).

Top module: `eth_rx_addr_filter`

## Requirements
- R1: After reset, `flt_valid` and `flt_accept` are 0, all three mode bits are 0, the hash table is all zeros and every exact-match entry is disabled, so a unicast frame is rejected.
- R2: `flt_valid` is a one-cycle pulse in the cycle after the sixth address byte is taken. Cycles with `rx_byte_vld` low do not advance the byte count. `flt_accept` is 0 whenever `flt_valid` is 0.
- R3: Each frame produces exactly one verdict. Bytes that follow the sixth address byte are ignored until the next start strobe.
- R4: `rx_sof` together with `rx_byte_vld` marks the first address byte and restarts the byte count and the CRC. A frame that stops short of six bytes yields no verdict and does not disturb the verdict of the frame that follows.
- R5: Mode bit 0 (register 0) accepts every frame, whatever its address.
- R6: The all-ones broadcast address is always accepted.
- R7: A destination is a group address when bit 0 of the first received byte is 1. Mode bit 1 accepts every group-address frame. It does not accept unicast frames.
- R8: The hash index is the upper 6 bits of the bit-reversed complement of the reflected CRC-32 (polynomial 0xEDB88320, preset to all ones, each byte processed LSB first, first received byte first) over the six address bytes. With mode bit 2 set, a group-address frame is accepted when the table bit at that index is 1. With none of bits 0 to 2 set, a non-broadcast group-address frame is rejected.
- R9: Index bit 5 selects the table half: register 1 holds table bits 0 to 31 and register 2 holds bits 32 to 63. Index bits 4 to 0 select the bit within that half.
- R10: A unicast frame is accepted when its address equals an enabled exact-match entry. Entry i is written at register 16+2i (address bytes 0 to 3, first received byte in bits 7:0) and at register 17+2i (bytes 4 and 5 in bits 15:0, enable in bit 31).
- R11: A disabled exact-match entry never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | REG_AW | Configuration register number |
| cfg_wr_data | input | 32 | Configuration write data |
| rx_sof | input | 1 | Start of frame, qualified by rx_byte_vld |
| rx_byte_vld | input | 1 | rx_byte carries a frame byte this cycle |
| rx_byte | input | 8 | Received frame byte |
| flt_valid | output | 1 | Verdict strobe |
| flt_accept | output | 1 | 1 = keep the frame, 0 = drop it |

## Verification
A byte counter that is off by one shifts the `flt_valid` pulse a cycle early or late, or drops it, and the pulse is checked on the exact cycle after the sixth byte of every frame sent. A corrupted CRC state or wrong index bit ordering turns a hash hit into a miss or the reverse on the very next group-address verdict. The hash tests place the single set bit in the correct half and in the opposite half, so a swapped half-select shows in the next verdict. A state machine that fails to restart or to enter `ST_HOLD` shows either as a missing verdict after a truncated frame or as an extra pulse while trailing bytes stream in.

// File: rtl/af_pkg.sv
package af_pkg;
    localparam logic [31:0] CRC_POLY    = 32'hEDB88320;
    localparam int          ADDR_BYTES  = 6;
    localparam int          MODE_W      = 3;
    localparam int          MODE_PROMISC = 0;
    localparam int          MODE_ALLMC   = 1;
    localparam int          MODE_HASHMC  = 2;
    localparam int          REG_MODE    = 0;
    localparam int          REG_HASH_LO = 1;
    localparam int          REG_HASH_HI = 2;
    localparam int          ENTRY_BASE  = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_HOLD = 2'd2
    } af_state_e;

    // Reflected CRC-32 update over one byte, LSB first
    function automatic logic [31:0] crc_byte(input logic [31:0] c_in, input logic [7:0] d);
        logic [31:0] c;
        c = c_in ^ {24'd0, d};
        for (int i = 0; i < 8; i++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
        end
        return c;
    endfunction
endpackage

// File: rtl/af_crc_unit.sv
module af_crc_unit
    import af_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       en,
    input  logic [7:0] data,
    output logic [5:0] hash_idx
);
    logic [31:0] crc_q;
    logic [31:0] crc_next;

    always_comb begin
        crc_next = crc_byte(start ? 32'hFFFF_FFFF : crc_q, data);
        // complement, reverse, keep top six: index bit 5-i is ~crc bit i
        for (int i = 0; i < 6; i++) begin
            hash_idx[5-i] = ~crc_next[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  crc_q <= 32'hFFFF_FFFF;
        else if (en) crc_q <= crc_next;
    end
endmodule

// File: rtl/af_perfect_bank.sv
module af_perfect_bank
    import af_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    parameter int REG_AW      = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [47:0]       cmp_addr,
    output logic              hit
);
    logic [NUM_ENTRIES-1:0] match;

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
        localparam logic [REG_AW-1:0] A_LO = REG_AW'(ENTRY_BASE + 2*i);
        localparam logic [REG_AW-1:0] A_HI = REG_AW'(ENTRY_BASE + 2*i + 1);
        logic [47:0] mac_q;
        logic        en_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mac_q <= '0;
                en_q  <= 1'b0;
            end else if (wr_en) begin
                if (wr_addr == A_LO) mac_q[31:0] <= wr_data;
                if (wr_addr == A_HI) begin
                    mac_q[47:32] <= wr_data[15:0];
                    en_q         <= wr_data[31];
                end
            end
        end

        assign match[i] = en_q && (mac_q == cmp_addr);
    end

    assign hit = |match;
endmodule

// File: rtl/af_frame_fsm.sv
module af_frame_fsm
    import af_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sof,
    input  logic        byte_vld,
    input  logic [7:0]  byte_data,
    input  logic        verdict,
    output logic        start,
    output logic        take,
    output logic [47:0] full_addr,
    output logic        dec_vld,
    output logic        dec_accept
);
    localparam int CNT_W = $clog2(ADDR_BYTES + 1);
    localparam int HEAD_W = 8 * (ADDR_BYTES - 1);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(ADDR_BYTES - 1);

    af_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, pos;
    logic [HEAD_W-1:0] head_q;
    logic             last;

    always_comb begin
        start     = sof && byte_vld;
        take      = start || (byte_vld && state_q == ST_ADDR);
        pos       = start ? '0 : cnt_q;
        last      = take && (pos == LAST_POS);
        full_addr = {byte_data, head_q};
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_ADDR;
            ST_ADDR: if (start) state_d = ST_ADDR;
                     else if (last) state_d = ST_HOLD;
            ST_HOLD: if (start) state_d = ST_ADDR;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (start)     cnt_q <= CNT_W'(1);
            else if (take) cnt_q <= cnt_q + 1'b1;
        end
    end

    for (genvar k = 0; k < ADDR_BYTES - 1; k++) begin : g_head
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           head_q[8*k +: 8] <= '0;
            else if (take && pos == CNT_W'(k))    head_q[8*k +: 8] <= byte_data;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_vld    <= 1'b0;
            dec_accept <= 1'b0;
        end else begin
            dec_vld    <= last;
            dec_accept <= last && verdict;
        end
    end
endmodule

// File: rtl/eth_rx_addr_filter.sv
module eth_rx_addr_filter
    import af_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    parameter int REG_AW      = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [REG_AW-1:0] cfg_wr_addr,
    input  logic [31:0]       cfg_wr_data,
    input  logic              rx_sof,
    input  logic              rx_byte_vld,
    input  logic [7:0]        rx_byte,
    output logic              flt_valid,
    output logic              flt_accept
);
    localparam logic [REG_AW-1:0] A_MODE    = REG_AW'(REG_MODE);
    localparam logic [REG_AW-1:0] A_HASH_LO = REG_AW'(REG_HASH_LO);
    localparam logic [REG_AW-1:0] A_HASH_HI = REG_AW'(REG_HASH_HI);

    logic [MODE_W-1:0] mode_q;
    logic [63:0]       hash_q;
    logic              start, take, uc_hit, verdict;
    logic [47:0]       full_addr;
    logic [5:0]        hash_idx;
    logic              is_group, is_bcast, hash_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            hash_q <= '0;
        end else if (cfg_wr_en) begin
            if (cfg_wr_addr == A_MODE)    mode_q        <= cfg_wr_data[MODE_W-1:0];
            if (cfg_wr_addr == A_HASH_LO) hash_q[31:0]  <= cfg_wr_data;
            if (cfg_wr_addr == A_HASH_HI) hash_q[63:32] <= cfg_wr_data;
        end
    end

    af_frame_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sof        (rx_sof),
        .byte_vld   (rx_byte_vld),
        .byte_data  (rx_byte),
        .verdict    (verdict),
        .start      (start),
        .take       (take),
        .full_addr  (full_addr),
        .dec_vld    (flt_valid),
        .dec_accept (flt_accept)
    );

    af_crc_unit u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .en       (take),
        .data     (rx_byte),
        .hash_idx (hash_idx)
    );

    af_perfect_bank #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .REG_AW      (REG_AW)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en),
        .wr_addr  (cfg_wr_addr),
        .wr_data  (cfg_wr_data),
        .cmp_addr (full_addr),
        .hit      (uc_hit)
    );

    always_comb begin
        is_group = full_addr[0];
        is_bcast = &full_addr;
        hash_bit = hash_q[hash_idx];  // index bit 5 picks the upper half
        verdict  = mode_q[MODE_PROMISC]
                 | is_bcast
                 | (is_group  & (mode_q[MODE_ALLMC] | (mode_q[MODE_HASHMC] & hash_bit)))
                 | (!is_group & uc_hit);
    end
endmodule

// File: rtl/af_filter_checker.sv
module af_filter_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        rx_sof,
    input logic        rx_byte_vld,
    input logic        flt_valid,
    input logic        flt_accept,
    input logic        mode_promisc,
    input logic [47:0] cand_addr
);
    AST_ACCEPT_QUAL:    assert property (@(posedge clk) disable iff (!rst_n) !flt_valid |-> !flt_accept);                   // R2
    AST_DEC_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n) flt_valid |-> $past(rx_byte_vld));             // R2
    AST_DEC_PULSE:      assert property (@(posedge clk) disable iff (!rst_n) flt_valid |=> !flt_valid);                     // R3
    AST_SOF_NO_DEC:     assert property (@(posedge clk) disable iff (!rst_n) $past(rx_sof && rx_byte_vld) |-> !flt_valid);  // R4
    AST_PROMISC:        assert property (@(posedge clk) disable iff (!rst_n) flt_valid && $past(mode_promisc) |-> flt_accept); // R5
    AST_BCAST:          assert property (@(posedge clk) disable iff (!rst_n) flt_valid && $past(&cand_addr) |-> flt_accept);  // R6
endmodule

bind eth_rx_addr_filter af_filter_checker u_af_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_sof       (rx_sof),
    .rx_byte_vld  (rx_byte_vld),
    .flt_valid    (flt_valid),
    .flt_accept   (flt_accept),
    .mode_promisc (mode_q[0]),
    .cand_addr    (full_addr)
);

// File: tb/test_eth_rx_addr_filter.sv
module test_eth_rx_addr_filter;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr_en = 1'b0;
    logic [AW-1:0] cfg_wr_addr = '0;
    logic [31:0]   cfg_wr_data = '0;
    logic          rx_sof = 1'b0;
    logic          rx_byte_vld = 1'b0;
    logic [7:0]    rx_byte = '0;
    logic          flt_valid, flt_accept;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eth_rx_addr_filter #(.NUM_ENTRIES(4), .REG_AW(AW)) i_eth_rx_addr_filter (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
        .rx_sof(rx_sof), .rx_byte_vld(rx_byte_vld), .rx_byte(rx_byte),
        .flt_valid(flt_valid), .flt_accept(flt_accept)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [5:0] ref_idx(input logic [47:0] a);
        logic [31:0] c, r, rv;
        logic fb;
        c = 32'hFFFF_FFFF;
        for (int k = 0; k < 48; k++) begin
            fb = c[0] ^ a[k];
            c  = c >> 1;
            if (fb) c = c ^ 32'hEDB88320;
        end
        r = ~c;
        for (int i = 0; i < 32; i++) rv[i] = r[31-i];
        return rv[31:26];
    endfunction

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_addr = AW'(addr); cfg_wr_data = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic set_hash(input logic [63:0] h);
        wr(1, h[31:0]);
        wr(2, h[63:32]);
    endtask

    task automatic set_entry(input int i, input logic [47:0] a, input bit en);
        wr(16 + 2*i, a[31:0]);
        wr(17 + 2*i, {en, 15'd0, a[47:32]});
    endtask

    // Sends six address bytes, optional idle gaps and trailing bytes, checks the verdict
    task automatic send(input logic [47:0] a, input bit gap, input int extra,
                        input bit exp, input string req);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (k > 0) chk(flt_valid == 1'b0, req, "early valid", flt_valid, 0);
            rx_sof = (k == 0); rx_byte_vld = 1'b1; rx_byte = a[8*k +: 8];
            if (gap && k < 5) begin
                @(negedge clk);
                chk(flt_valid == 1'b0, req, "valid during gap", flt_valid, 0);
                rx_sof = 1'b0; rx_byte_vld = 1'b0;
            end
        end
        @(negedge clk);
        chk(flt_valid == 1'b1, req, "valid pulse", flt_valid, 1);
        chk(flt_accept == exp, req, "accept", flt_accept, exp);
        rx_sof = 1'b0; rx_byte_vld = (extra > 0); rx_byte = 8'hA5;
        for (int e = 0; e < extra; e++) begin
            @(negedge clk);
            chk(flt_valid == 1'b0, "R3", "valid on trailing byte", flt_valid, 0);
            rx_byte_vld = (e + 1 < extra); rx_byte = 8'(e);
        end
        @(negedge clk);
        chk(flt_valid == 1'b0, req, "valid after pulse", flt_valid, 0);
        rx_byte_vld = 1'b0;
    endtask

    localparam logic [47:0] STATION = 48'h5544_3322_1102;
    localparam logic [47:0] ALT_UC  = 48'hEEDD_CCBB_AA0A;
    localparam logic [47:0] BCAST   = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] GRP     = 48'h0300_005E_0001;

    task automatic t_reset();
        @(negedge clk);
        chk(flt_valid == 1'b0 && flt_accept == 1'b0, "R1", "outputs in reset", {flt_valid, flt_accept}, 0);
        rst_n = 1'b1;
        send(STATION, 1'b0, 0, 1'b0, "R1");
        send(BCAST, 1'b0, 0, 1'b1, "R6");
    endtask

    task automatic t_perfect();
        set_entry(0, STATION, 1'b1);
        set_entry(3, ALT_UC, 1'b1);
        send(STATION, 1'b0, 0, 1'b1, "R10");
        send(ALT_UC, 1'b0, 0, 1'b1, "R10");
        send(STATION ^ 48'h0100_0000_0000, 1'b0, 0, 1'b0, "R10");
        set_entry(3, ALT_UC, 1'b0);
        send(ALT_UC, 1'b0, 0, 1'b0, "R11");
        send(STATION, 1'b0, 0, 1'b1, "R11");
    endtask

    task automatic t_modes();
        send(GRP, 1'b0, 0, 1'b0, "R8");
        wr(0, 32'h2);
        send(GRP, 1'b0, 0, 1'b1, "R7");
        send(ALT_UC, 1'b0, 0, 1'b0, "R7");
        wr(0, 32'h1);
        send(ALT_UC, 1'b0, 0, 1'b1, "R5");
        send(GRP, 1'b0, 0, 1'b1, "R5");
        wr(0, 32'h0);
        send(BCAST, 1'b0, 0, 1'b1, "R6");
    endtask

    task automatic t_hash();
        logic [47:0] mc_lo, mc_hi, cand;
        logic [5:0]  ilo, ihi;
        bit flo, fhi;
        flo = 0; fhi = 0; mc_lo = '0; mc_hi = '0;
        for (int x = 0; x < 256; x++) begin
            cand = {8'(x), 40'h00_005E_0001};
            if (!ref_idx(cand)[5] && !flo) begin mc_lo = cand; flo = 1; end
            if ( ref_idx(cand)[5] && !fhi) begin mc_hi = cand; fhi = 1; end
        end
        ilo = ref_idx(mc_lo);
        ihi = ref_idx(mc_hi);
        wr(0, 32'h4);
        set_hash(64'd0);
        send(mc_lo, 1'b0, 0, 1'b0, "R8");
        set_hash(64'd1 << ilo);
        send(mc_lo, 1'b0, 0, 1'b1, "R8");
        set_hash(64'd1 << (ilo ^ 6'd32));
        send(mc_lo, 1'b0, 0, 1'b0, "R9");
        set_hash(64'd1 << ihi);
        send(mc_hi, 1'b0, 0, 1'b1, "R9");
        set_hash(64'd1 << (ihi ^ 6'd32));
        send(mc_hi, 1'b0, 0, 1'b0, "R9");
        set_hash(64'd1 << ihi);
        wr(0, 32'h0);
        send(mc_hi, 1'b0, 0, 1'b0, "R8");
        wr(0, 32'h4);
        send(mc_hi, 1'b1, 0, 1'b1, "R8");
        wr(0, 32'h0);
    endtask

    task automatic t_timing();
        send(STATION, 1'b1, 0, 1'b1, "R2");
        send(STATION, 1'b0, 9, 1'b1, "R3");
        send(ALT_UC, 1'b1, 4, 1'b0, "R3");
    endtask

    task automatic t_restart();
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            rx_sof = (k == 0); rx_byte_vld = 1'b1; rx_byte = ALT_UC[8*k +: 8];
        end
        @(negedge clk);
        rx_sof = 1'b0; rx_byte_vld = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(flt_valid == 1'b0, "R4", "verdict from truncated frame", flt_valid, 0);
        end
        send(STATION, 1'b0, 0, 1'b1, "R4");
        // truncated frame directly followed by a new start
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            rx_sof = (k == 0); rx_byte_vld = 1'b1; rx_byte = STATION[8*k +: 8];
        end
        send(ALT_UC, 1'b0, 0, 1'b0, "R4");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_perfect();
        t_modes();
        t_hash();
        t_timing();
        t_restart();
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule